// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog that software arms and services through a single 32-bit control word at offset 0x1C of a small memory-mapped port. A selectable prescaler turns the reference clock into ticks, and the ticks advance a counter. When the counter reaches the chosen interval, an interrupt flag sets. If the flag is not cleared and the count restarted, a grace period of a fixed tick count follows. At the end of that grace period the block can issue a one-cycle reset request.

The interrupt stage and the reset stage have separate enables. The two status flags are cleared by writing a one to them. Clearing the run bit freezes both the prescaler and the tick counter, and setting it again resumes from the frozen point. A watchdog-triggered reset, or the external system-reset input, returns the control word to its defaults but keeps the reset flag, so software can tell afterwards why the system restarted. The power-on reset clears everything, the reset flag included.

The sequencing is a three-state machine:
- `ST_INTERVAL` counts ticks toward the interval.
- `ST_GRACE` counts the grace ticks after the interrupt flag has set.
- `ST_HOLD` is parked and does nothing more.

The transitions are as follows:
- *interval hit* takes `ST_INTERVAL` to `ST_GRACE` and sets the flag.
- *grace hit with reset enabled* takes `ST_GRACE` to `ST_INTERVAL` and fires the reset request.
- *grace hit with reset disabled* takes `ST_GRACE` to `ST_HOLD`.
- *restart* is a restart-bit write, a change of clock select or interval select, or a system reset. It takes any state back to `ST_INTERVAL` with cleared counters.
- `ST_HOLD` stays where it is until a restart.

Top module: `wdog_timer`

## Requirements
- R1: After power-on reset the control word reads 0x0000_0400, with clock select = 1 and every other bit 0. `irq` and `rst_req` are low.
- R2: Clock select (bits 11:10) picks 2^PRE_Lk reference cycles per tick. Code 0 is always 1 cycle per tick. The defaults give 256, 2048 and 65536 for codes 1, 2 and 3.
- R3: Count the cycles after the edge that captures a write with the run bit (bit 7) set. The interrupt flag (bit 3) sets exactly D·2^(IVL_BASE + IVL_STEP·s) cycles after that edge, where D is the tick length and s is the interval select (bits 5:4). The defaults give 2^(14+2s) ticks. One cycle earlier the flag is still clear.
- R4: The interrupt flag sets whether or not interrupt enable (bit 6) is 1. `irq` is high only while both the flag and interrupt enable are 1.
- R5: GRACE_TICKS ticks after the flag sets (default 1024), `rst_req` pulses high for exactly one cycle, but only if reset enable (bit 1) is 1. With reset enable at 0 no pulse ever follows, and the interrupt flag stays set.
- R6: In the cycle of the `rst_req` pulse and after it, the control word is 0x0000_0404: the defaults plus the reset flag (bit 2).
- R7: Writing 1 to bit 3 or bit 2 clears that flag, and writing 0 leaves it unchanged. Bit 0 restarts the count and always reads 0.
- R8: With the run bit at 0 the count is frozen, and no flag or request appears however long the pause lasts. Setting the run bit again resumes from the frozen count.
- R9: A one-cycle `sys_rst` returns the control word to its defaults and keeps the reset flag as it was.
- R10: A write that changes clock select or interval select restarts the prescaler and the tick count, just as the restart bit does.
- R11: A read returns data one cycle after the request. Any other offset reads 0 and ignores writes. Reserved bits (31:12, 9:8 and bit 0) read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| sys_rst | input | 1 | Synchronous system reset; keeps the reset flag |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the strobe |
| irq | output | 1 | Interrupt line (flag and interrupt enable) |
| rst_req | output | 1 | One-cycle reset request pulse |

## Verification
A wrong prescaler limit or interval target shows at the `irq` port as an edge that lands one or more cycles early or late. The bench therefore samples the cycle before and the cycle of the expected edge for every clock-select and interval-select pairing.

A state machine that fails to leave `ST_GRACE`, or leaves it wrongly, shows as a missing or doubled `rst_req` pulse. A lost reset flag or a lost paused count shows in the next control-word read, or in an interrupt edge that moves by whole ticks after resume. All of these appear within one interval plus one grace period.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        ST_INTERVAL = 2'd0,
        ST_GRACE    = 2'd1,
        ST_HOLD     = 2'd2
    } wd_state_e;

    typedef struct packed {
        logic [1:0] clk_sel;
        logic       run;
        logic       irq_en;
        logic [1:0] ivl_sel;
        logic       irq_flag;
        logic       rst_flag;
        logic       rst_en;
    } wd_ctl_t;

    localparam wd_ctl_t CTL_RESET = '{clk_sel: 2'd1, default: '0};

    // Bit positions are what software decodes; keep them fixed.
    function automatic logic [31:0] ctl_to_word(wd_ctl_t c);
        logic [31:0] w;
        w        = '0;
        w[11:10] = c.clk_sel;
        w[7]     = c.run;
        w[6]     = c.irq_en;
        w[5:4]   = c.ivl_sel;
        w[3]     = c.irq_flag;
        w[2]     = c.rst_flag;
        w[1]     = c.rst_en;
        return w;
    endfunction

endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int unsigned PRE_L1 = 8,
    parameter int unsigned PRE_L2 = 11,
    parameter int unsigned PRE_L3 = 16
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       clr,
    input  logic       run,
    input  logic [1:0] sel,
    output logic       tick
);

    function automatic int unsigned max_of(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    localparam int unsigned LMAX = max_of(max_of(PRE_L1, PRE_L2), PRE_L3);
    localparam int unsigned PW   = (LMAX < 1) ? 1 : LMAX;
    localparam int unsigned LOGS [4] = '{0, PRE_L1, PRE_L2, PRE_L3};

    function automatic logic [PW-1:0] lim_of(int unsigned l);
        logic [63:0] v;
        v = (64'd1 << l) - 64'd1;
        return v[PW-1:0];
    endfunction

    logic [PW-1:0] lim_tab [4];
    logic [PW-1:0] lim_sel;
    logic [PW-1:0] pre_q;

    for (genvar g = 0; g < 4; g++) begin : g_lim
        assign lim_tab[g] = lim_of(LOGS[g]);
    end

    always_comb begin
        unique case (sel)
            2'd0:    lim_sel = lim_tab[0];
            2'd1:    lim_sel = lim_tab[1];
            2'd2:    lim_sel = lim_tab[2];
            default: lim_sel = lim_tab[3];
        endcase
    end

    assign tick = run && (pre_q == lim_sel);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            pre_q <= '0;
        end else if (clr) begin
            pre_q <= '0;
        end else if (run) begin
            pre_q <= tick ? '0 : pre_q + 1'b1;
        end
    end

    // R8: a paused prescaler keeps its phase
    a_r8_prescale_frozen: assert property (@(posedge clk) disable iff (!por_n)
        (!run && !clr) |=> $stable(pre_q));

    // R2: phase never passes the selected divisor
    a_r2_phase_in_range: assert property (@(posedge clk) disable iff (!por_n)
        pre_q <= lim_sel);

endmodule

// File: rtl/wdog_tick_count.sv
module wdog_tick_count #(
    parameter int unsigned CW = 21
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          clr,
    input  logic          tick,
    output logic [CW-1:0] cnt
);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R8: without a tick the count holds
    a_r8_count_held: assert property (@(posedge clk) disable iff (!por_n)
        (!clr && !tick) |=> $stable(cnt));

endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
#(
    parameter int unsigned CW          = 21,
    parameter int unsigned IVL_BASE    = 14,
    parameter int unsigned IVL_STEP    = 2,
    parameter int unsigned GRACE_TICKS = 1024
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          restart,
    input  logic          tick,
    input  logic [CW-1:0] cnt,
    input  logic [1:0]    ivl_sel,
    input  logic          rst_en,
    output logic          set_irq,
    output logic          fire,
    output logic          cnt_clr
);

    function automatic logic [CW-1:0] last_of(int unsigned k);
        logic [63:0] v;
        v = (64'd1 << k) - 64'd1;
        return v[CW-1:0];
    endfunction

    localparam logic [CW-1:0] GRACE_LAST = CW'(GRACE_TICKS - 1);

    logic [CW-1:0] last_tab [4];
    logic [CW-1:0] ivl_last;
    wd_state_e     state_q, state_d;
    logic          ivl_hit, grace_hit;

    for (genvar g = 0; g < 4; g++) begin : g_last
        assign last_tab[g] = last_of(IVL_BASE + IVL_STEP * g);
    end

    always_comb begin
        unique case (ivl_sel)
            2'd0:    ivl_last = last_tab[0];
            2'd1:    ivl_last = last_tab[1];
            2'd2:    ivl_last = last_tab[2];
            default: ivl_last = last_tab[3];
        endcase
    end

    assign ivl_hit   = tick && (cnt == ivl_last);
    assign grace_hit = tick && (cnt == GRACE_LAST);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INTERVAL: if (ivl_hit)   state_d = ST_GRACE;
            ST_GRACE:    if (grace_hit) state_d = rst_en ? ST_INTERVAL : ST_HOLD;
            ST_HOLD:     state_d = ST_HOLD;
            default:     state_d = ST_INTERVAL;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= ST_INTERVAL;
        end else if (restart) begin
            state_q <= ST_INTERVAL;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        set_irq = 1'b0;
        fire    = 1'b0;
        cnt_clr = 1'b0;
        unique case (state_q)
            ST_INTERVAL: begin
                set_irq = ivl_hit && !restart;
                cnt_clr = ivl_hit;
            end
            ST_GRACE: begin
                fire    = grace_hit && rst_en && !restart;
                cnt_clr = grace_hit;
            end
            ST_HOLD: cnt_clr = 1'b1;
            default: cnt_clr = 1'b1;
        endcase
    end

    // R5: a parked watchdog never requests a reset
    a_r5_hold_silent: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_HOLD) |-> !fire);

    // R3: interval count never passes its target
    a_r3_below_target: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_INTERVAL) |-> (cnt <= ivl_last));

    // R5: grace count never passes its length
    a_r5_grace_bound: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_GRACE) |-> (cnt <= GRACE_LAST));

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int unsigned       ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] CTL_OFFSET  = 'h1C,
    parameter int unsigned       PRE_L1      = 8,
    parameter int unsigned       PRE_L2      = 11,
    parameter int unsigned       PRE_L3      = 16,
    parameter int unsigned       IVL_BASE    = 14,
    parameter int unsigned       IVL_STEP    = 2,
    parameter int unsigned       GRACE_TICKS = 1024
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              rst_req
);

    localparam int unsigned IVL_TOP = IVL_BASE + 3 * IVL_STEP;
    localparam int unsigned GR_W    = $clog2(GRACE_TICKS);
    localparam int unsigned CW      = ((IVL_TOP > GR_W) ? IVL_TOP : GR_W) + 1;

    wd_ctl_t       ctl_q, ctl_d;
    logic          hit, wr_ctl, ext_restart;
    logic          tick, set_irq, fire, cnt_clr;
    logic [CW-1:0] cnt;
    logic          unused_wdata;

    assign unused_wdata = ^{bus_wdata[31:12], bus_wdata[9:8]};

    assign hit    = bus_sel && (bus_addr == CTL_OFFSET);
    assign wr_ctl = hit && bus_wr;

    assign ext_restart = sys_rst ||
        (wr_ctl && (bus_wdata[0] ||
                    (bus_wdata[11:10] != ctl_q.clk_sel) ||
                    (bus_wdata[5:4]   != ctl_q.ivl_sel)));

    wdog_prescaler #(
        .PRE_L1 (PRE_L1),
        .PRE_L2 (PRE_L2),
        .PRE_L3 (PRE_L3)
    ) u_pre (
        .clk   (clk),
        .por_n (por_n),
        .clr   (ext_restart || fire),
        .run   (ctl_q.run),
        .sel   (ctl_q.clk_sel),
        .tick  (tick)
    );

    wdog_tick_count #(.CW(CW)) u_cnt (
        .clk   (clk),
        .por_n (por_n),
        .clr   (ext_restart || cnt_clr),
        .tick  (tick),
        .cnt   (cnt)
    );

    wdog_fsm #(
        .CW          (CW),
        .IVL_BASE    (IVL_BASE),
        .IVL_STEP    (IVL_STEP),
        .GRACE_TICKS (GRACE_TICKS)
    ) u_fsm (
        .clk     (clk),
        .por_n   (por_n),
        .restart (ext_restart),
        .tick    (tick),
        .cnt     (cnt),
        .ivl_sel (ctl_q.ivl_sel),
        .rst_en  (ctl_q.rst_en),
        .set_irq (set_irq),
        .fire    (fire),
        .cnt_clr (cnt_clr)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (fire) begin
            ctl_d          = CTL_RESET;
            ctl_d.rst_flag = 1'b1;
        end else if (sys_rst) begin
            ctl_d          = CTL_RESET;
            ctl_d.rst_flag = ctl_q.rst_flag;
        end else begin
            if (wr_ctl) begin
                ctl_d.clk_sel  = bus_wdata[11:10];
                ctl_d.run      = bus_wdata[7];
                ctl_d.irq_en   = bus_wdata[6];
                ctl_d.ivl_sel  = bus_wdata[5:4];
                ctl_d.irq_flag = ctl_q.irq_flag & ~bus_wdata[3];
                ctl_d.rst_flag = ctl_q.rst_flag & ~bus_wdata[2];
                ctl_d.rst_en   = bus_wdata[1];
            end
            if (set_irq) begin
                ctl_d.irq_flag = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            ctl_q     <= CTL_RESET;
            bus_rdata <= '0;
            rst_req   <= 1'b0;
        end else begin
            ctl_q   <= ctl_d;
            rst_req <= fire;
            if (bus_sel && !bus_wr) begin
                bus_rdata <= hit ? ctl_to_word(ctl_q) : '0;
            end
        end
    end

    assign irq = ctl_q.irq_flag && ctl_q.irq_en;

    // R5: the request lasts a single cycle
    a_r5_req_single: assert property (@(posedge clk) disable iff (!por_n)
        rst_req |=> !rst_req);

    // R6: the request coincides with the defaults plus the reset flag
    a_r6_word_on_req: assert property (@(posedge clk) disable iff (!por_n)
        rst_req |-> (ctl_to_word(ctl_q) == 32'h0000_0404));

    // R9: system reset keeps the reset flag
    a_r9_flag_kept: assert property (@(posedge clk) disable iff (!por_n)
        (sys_rst && !fire) |=> (ctl_q.rst_flag == $past(ctl_q.rst_flag)));

endmodule

// File: tb/wdog_timer_tb.sv
module wdog_timer_tb;

    localparam int unsigned PL1 = 1, PL2 = 2, PL3 = 3;
    localparam int unsigned IB = 2, IS = 1, GT = 8;
    localparam logic [7:0]  OFS = 8'h1C;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        sys_rst = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, rst_req;

    int n_cmp = 0;
    int n_bad = 0;
    int pulses = 0;

    always #4 clk = ~clk;

    wdog_timer #(
        .ADDR_W(8), .CTL_OFFSET(OFS),
        .PRE_L1(PL1), .PRE_L2(PL2), .PRE_L3(PL3),
        .IVL_BASE(IB), .IVL_STEP(IS), .GRACE_TICKS(GT)
    ) u_dut (
        .clk(clk), .por_n(por_n), .sys_rst(sys_rst),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .rst_req(rst_req)
    );

    always @(posedge clk) if (rst_req) pulses <= pulses + 1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_por();
        por_n = 1'b0;
        waitc(2);
        por_n = 1'b1;
        waitc(1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        int p0;
        @(negedge clk);
        do_por();

        // R1 reset state
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 rst_req", {31'd0, rst_req}, 32'd0);
        rd(OFS, rv); check("R1 word", rv, 32'h400);

        // R11 other offsets, reserved bits
        rd(8'h18, rv); check("R11 other offset read", rv, 32'h0);
        wr(8'h20, 32'hFFFF_FFFF);
        rd(OFS, rv); check("R11 write elsewhere ignored", rv, 32'h400);
        wr(OFS, 32'hFFFF_FFFF);
        rd(OFS, rv); check("R11 reserved read zero", rv, 32'hCF2);
        do_por();

        // R2 R3 sweep over every divisor and interval
        for (int cs = 0; cs < 4; cs++) begin
            for (int iv = 0; iv < 4; iv++) begin
                int d, t;
                d = 1 << ((cs == 0) ? 0 : (cs == 1) ? PL1 : (cs == 2) ? PL2 : PL3);
                t = d * (1 << (IB + IS * iv));
                wr(OFS, (cs << 10) | 32'hC9 | (iv << 4));
                waitc(t - 1);
                check($sformatf("R3 early cs=%0d iv=%0d", cs, iv), {31'd0, irq}, 32'd0);
                waitc(1);
                check($sformatf("R2 on time cs=%0d iv=%0d", cs, iv), {31'd0, irq}, 32'd1);
            end
        end

        // R7 write-one-to-clear
        do_por();
        wr(OFS, 32'hC1);
        waitc(4);
        check("R7 flag up", {31'd0, irq}, 32'd1);
        wr(OFS, 32'hC0);
        rd(OFS, rv); check("R7 zero leaves flag, restart reads 0", rv, 32'hC8);
        wr(OFS, 32'hC8);
        rd(OFS, rv); check("R7 one clears flag", rv, 32'hC0);
        check("R7 irq low", {31'd0, irq}, 32'd0);

        // R4 R5 no enables: flag but no irq, no reset
        do_por();
        p0 = pulses;
        wr(OFS, 32'h89);
        waitc(4);
        check("R4 irq masked", {31'd0, irq}, 32'd0);
        waitc(40);
        rd(OFS, rv); check("R5 flag stays, no reset flag", rv, 32'h88);
        check("R5 no pulse", pulses - p0, 32'd0);

        // R5 reset enable only
        p0 = pulses;
        wr(OFS, 32'h8B);
        waitc(4);
        check("R4 irq masked with reset stage", {31'd0, irq}, 32'd0);
        waitc(9);
        check("R5 one pulse", pulses - p0, 32'd1);
        rd(OFS, rv); check("R6 word after reset only", rv, 32'h404);

        // R5 R6 full sequence with pulse timing
        do_por();
        wr(OFS, 32'hC3);
        waitc(3);
        check("R3 before flag", {31'd0, irq}, 32'd0);
        waitc(1);
        check("R4 irq raised", {31'd0, irq}, 32'd1);
        waitc(7);
        check("R5 not yet", {31'd0, rst_req}, 32'd0);
        waitc(1);
        check("R5 pulse", {31'd0, rst_req}, 32'd1);
        waitc(1);
        check("R5 single cycle", {31'd0, rst_req}, 32'd0);
        rd(OFS, rv); check("R6 word", rv, 32'h404);

        // R9 system reset keeps reset flag
        wr(OFS, 32'h4C0);
        rd(OFS, rv); check("R9 before", rv, 32'h4C4);
        sys_rst = 1'b1; @(posedge clk); @(negedge clk); sys_rst = 1'b0;
        rd(OFS, rv); check("R9 after sys_rst", rv, 32'h404);
        wr(OFS, 32'h404);
        rd(OFS, rv); check("R7 reset flag cleared", rv, 32'h400);
        wr(OFS, 32'h404);
        do_por();
        rd(OFS, rv); check("R1 por clears all", rv, 32'h400);

        // R10 interval change restarts count
        wr(OFS, 32'hC1);
        waitc(1);
        wr(OFS, 32'hD0);
        waitc(7);
        check("R10 no early flag", {31'd0, irq}, 32'd0);
        waitc(1);
        check("R10 fresh count", {31'd0, irq}, 32'd1);

        // R8 pause and resume
        do_por();
        wr(OFS, 32'h4D1);
        waitc(7);
        wr(OFS, 32'h450);
        waitc(50);
        check("R8 paused irq", {31'd0, irq}, 32'd0);
        rd(OFS, rv); check("R8 paused word", rv, 32'h450);
        wr(OFS, 32'h4D0);
        waitc(7);
        check("R8 resumed early", {31'd0, irq}, 32'd0);
        waitc(1);
        check("R8 resumed on time", {31'd0, irq}, 32'd1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule